// File: doc/BRIEF.md
# Programmable TFT Raster Timing Generator

This block produces the raster control signals that a TFT panel driver needs: a pixel-rate enable, a 50%-duty pixel clock, horizontal and vertical sync, a data-enable that covers the visible area, and a strobe that marks the last pixel of each line. It runs from the system clock. The pixel rate is that clock divided by twice the divisor field plus one.

Every horizontal and vertical segment is set by an input field that holds its length minus one: sync width, back porch, active count and front porch, in that order. A line and a frame are each the sum of their four segments. All fields are sampled together at the start of each frame, so new values written in the middle of a frame take effect at the next frame boundary. The current position within the line and within the frame, blanking included, is visible on two outputs.

Each of horizontal sync, vertical sync, data-enable and pixel clock has its own live invert input. Any of them can be made active-low without waiting for a frame boundary.

Top module: `tft_raster_gen`

## Requirements
- R1: While `rst` is high, `pixEn` is 0. From reset until the first `pixEn` after reset is released, and during that first `pixEn` cycle, `hsyncOut`, `vsyncOut`, `denOut` and `pclkOut` equal their invert inputs (inactive), `lineEnd` is 0, and `hPos` and `vPos` are 0. That first `pixEn` starts the first frame.
- R2: `pixEn` is a single-cycle pulse. Consecutive pulses are exactly 2*(divSel+1) clock cycles apart.
- R3: Once running, `pclkOut` is active for divSel+1 cycles, ending with the `pixEn` cycle, and then inactive for divSel+1 cycles.
- R4: `hPos` advances by one on each `pixEn`. It wraps to 0 after (HS+1)+(HB+1)+(HA+1)+(HF+1) pixels, where HS, HB, HA and HF are the horizontal sync, back porch, active and front porch fields. Horizontal sync is active while hPos <= HS.
- R5: `lineEnd` is 1 exactly while hPos equals the last index of the line, and 0 at every other position.
- R6: `vPos` advances when a line wraps and covers (VS+1)+(VB+1)+(VA+1)+(VF+1) lines. Vertical sync is active while vPos <= VS. After the last pixel of the last line, both positions return to 0.
- R7: Data-enable is active only when HS+HB+2 <= hPos <= HS+HB+HA+2 and, at the same time, VS+VB+2 <= vPos <= VS+VB+VA+2.
- R8: The divisor and all eight segment fields are sampled only when a frame starts. A change in the middle of a frame has no effect on the rest of that frame and takes effect from the next frame.
- R9: Each invert input is applied live. A 1 on `invHsync`, `invVsync`, `invDen` or `invPclk` inverts the matching output (raw level XOR invert), including while idle.
- R10: With divSel at its maximum of 1023, `pixEn` pulses are 2048 cycles apart and `pclkOut` is active for 1024 of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| divSel | input | DIV_W | Pixel clock divisor field (rate = clk / (2*(divSel+1))) |
| hSyncLen | input | H_W | Horizontal sync width minus one |
| hBackLen | input | H_W | Horizontal back porch minus one |
| hActLen | input | H_W | Active pixels per line minus one |
| hFrontLen | input | H_W | Horizontal front porch minus one |
| vSyncLen | input | V_W | Vertical sync width in lines minus one |
| vBackLen | input | V_W | Vertical back porch minus one |
| vActLen | input | V_W | Active lines minus one |
| vFrontLen | input | V_W | Vertical front porch minus one |
| invHsync | input | 1 | Invert horizontal sync output |
| invVsync | input | 1 | Invert vertical sync output |
| invDen | input | 1 | Invert data-enable output |
| invPclk | input | 1 | Invert pixel clock output |
| pixEn | output | 1 | One-cycle pixel enable, marks the end of each pixel |
| pclkOut | output | 1 | 50%-duty pixel clock |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| denOut | output | 1 | Data-enable for the active region |
| lineEnd | output | 1 | High during the last pixel of each line |
| hPos | output | H_W+2 | Pixel index within the line, blanking included |
| vPos | output | V_W+2 | Line index within the frame, blanking included |

## Verification
The hardest case to reach is a field change landing mid-frame, because that change must stay invisible until the frame wraps. The stimulus releases reset with one small geometry at the fastest divisor. About twenty cycles into that frame, it switches every field, the divisor included, to a second geometry. The scoreboard expects one full frame of the first shape followed by one full frame of the second, pixel by pixel. A separate run at the largest divisor measures the pulse spacing and the pixel clock duty cycle directly.

// File: rtl/raster_pkg.sv
package raster_pkg;
  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic pixTick;    // last system cycle of a pixel period
    logic frameLoad;  // pixTick that also opens a new frame
    logic running;    // first frame has begun
    logic pclkPhase;  // high half of the pixel clock
  } strobe_t;
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divSel,
  input  logic             frameEnd,
  output strobe_t          stb
);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] shadowDiv;
  logic [DIV_W-1:0] reloadVal;
  logic             phase;
  logic             running;
  logic             termCnt;
  logic             tick;
  logic             loadNow;

  always_comb begin
    termCnt   = (divCnt == '0);
    tick      = termCnt & phase;
    loadNow   = tick & (~running | frameEnd);
    reloadVal = (~running | loadNow) ? divSel : shadowDiv;
    stb.pixTick   = tick;
    stb.frameLoad = loadNow;
    stb.running   = running;
    stb.pclkPhase = phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt    <= '0;
      shadowDiv <= '0;
      phase     <= 1'b0;
      running   <= 1'b0;
    end else begin
      if (termCnt) begin
        divCnt <= reloadVal;
        phase  <= ~phase;
      end else begin
        divCnt <= divCnt - 1'b1;
      end
      if (loadNow) begin
        running   <= 1'b1;
        shadowDiv <= divSel;
      end
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R2
  AST_PCLK_FALLS: assert property (@(posedge clk) disable iff (rst)
    tick |=> !phase); // R3
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !loadNow |=> $stable(shadowDiv)); // R8

endmodule

// File: rtl/raster_axis.sv
module raster_axis #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] syncLen,
  input  logic [W-1:0] backLen,
  input  logic [W-1:0] actLen,
  input  logic [W-1:0] frontLen,
  output logic [W+1:0] pos,
  output logic         inSync,
  output logic         inActive,
  output logic         atLast
);

  localparam int CW = W + 2;

  logic [W-1:0]  sSync, sBack, sAct, sFront;
  logic [CW-1:0] syncEnd, actStart, actEnd, lastIdx;

  always_comb begin
    syncEnd  = CW'(sSync) + CW'(1);
    actStart = syncEnd + CW'(sBack) + CW'(1);
    actEnd   = actStart + CW'(sAct) + CW'(1);
    lastIdx  = actEnd + CW'(sFront);
    inSync   = (pos < syncEnd);
    inActive = (pos >= actStart) && (pos < actEnd);
    atLast   = (pos == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      sSync  <= '0;
      sBack  <= '0;
      sAct   <= '0;
      sFront <= '0;
    end else if (load) begin
      pos    <= '0;
      sSync  <= syncLen;
      sBack  <= backLen;
      sAct   <= actLen;
      sFront <= frontLen;
    end else if (step) begin
      pos <= atLast ? '0 : pos + 1'b1;
    end
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
    pos <= lastIdx); // R4
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && atLast && !load) |=> (pos == '0)); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({sSync, sBack, sAct, sFront})); // R8

endmodule

// File: rtl/raster_datapath.sv
module raster_datapath
  import raster_pkg::*;
#(
  parameter int H_W = 10,
  parameter int V_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  strobe_t        stb,
  input  logic [H_W-1:0] hSyncLen,
  input  logic [H_W-1:0] hBackLen,
  input  logic [H_W-1:0] hActLen,
  input  logic [H_W-1:0] hFrontLen,
  input  logic [V_W-1:0] vSyncLen,
  input  logic [V_W-1:0] vBackLen,
  input  logic [V_W-1:0] vActLen,
  input  logic [V_W-1:0] vFrontLen,
  output logic [H_W+1:0] hPos,
  output logic [V_W+1:0] vPos,
  output logic           hsyncRaw,
  output logic           vsyncRaw,
  output logic           denRaw,
  output logic           lineEndRaw,
  output logic           frameEnd
);

  logic hStep, vStep;
  logic hInSync, hInAct, hLast;
  logic vInSync, vInAct, vLast;

  assign hStep = stb.pixTick & stb.running;
  assign vStep = hStep & hLast;

  raster_axis #(.W(H_W)) uHorz (
    .clk(clk), .rst(rst), .load(stb.frameLoad), .step(hStep),
    .syncLen(hSyncLen), .backLen(hBackLen), .actLen(hActLen), .frontLen(hFrontLen),
    .pos(hPos), .inSync(hInSync), .inActive(hInAct), .atLast(hLast)
  );

  raster_axis #(.W(V_W)) uVert (
    .clk(clk), .rst(rst), .load(stb.frameLoad), .step(vStep),
    .syncLen(vSyncLen), .backLen(vBackLen), .actLen(vActLen), .frontLen(vFrontLen),
    .pos(vPos), .inSync(vInSync), .inActive(vInAct), .atLast(vLast)
  );

  always_comb begin
    hsyncRaw   = stb.running & hInSync;
    vsyncRaw   = stb.running & vInSync;
    denRaw     = stb.running & hInAct & vInAct;
    lineEndRaw = stb.running & hLast;
    frameEnd   = hLast & vLast;
  end

  AST_DEN_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (rst)
    denRaw |-> (!hsyncRaw && !vsyncRaw)); // R7
  AST_LINE_END_WRAP: assert property (@(posedge clk) disable iff (rst)
    (lineEndRaw && stb.pixTick) |=> (hPos == '0)); // R5
  AST_FRAME_TOP: assert property (@(posedge clk) disable iff (rst)
    stb.frameLoad |=> (hPos == '0 && vPos == '0)); // R6

endmodule

// File: rtl/tft_raster_gen.sv
module tft_raster_gen
  import raster_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int H_W   = 10,
  parameter int V_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divSel,
  input  logic [H_W-1:0]   hSyncLen,
  input  logic [H_W-1:0]   hBackLen,
  input  logic [H_W-1:0]   hActLen,
  input  logic [H_W-1:0]   hFrontLen,
  input  logic [V_W-1:0]   vSyncLen,
  input  logic [V_W-1:0]   vBackLen,
  input  logic [V_W-1:0]   vActLen,
  input  logic [V_W-1:0]   vFrontLen,
  input  logic             invHsync,
  input  logic             invVsync,
  input  logic             invDen,
  input  logic             invPclk,
  output logic             pixEn,
  output logic             pclkOut,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             denOut,
  output logic             lineEnd,
  output logic [H_W+1:0]   hPos,
  output logic [V_W+1:0]   vPos
);

  strobe_t stb;
  logic    frameEnd;
  logic    hsyncRaw, vsyncRaw, denRaw, lineEndRaw;

  raster_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rst(rst), .divSel(divSel), .frameEnd(frameEnd), .stb(stb)
  );

  raster_datapath #(.H_W(H_W), .V_W(V_W)) uPath (
    .clk(clk), .rst(rst), .stb(stb),
    .hSyncLen(hSyncLen), .hBackLen(hBackLen), .hActLen(hActLen), .hFrontLen(hFrontLen),
    .vSyncLen(vSyncLen), .vBackLen(vBackLen), .vActLen(vActLen), .vFrontLen(vFrontLen),
    .hPos(hPos), .vPos(vPos),
    .hsyncRaw(hsyncRaw), .vsyncRaw(vsyncRaw), .denRaw(denRaw),
    .lineEndRaw(lineEndRaw), .frameEnd(frameEnd)
  );

  always_comb begin
    pixEn    = stb.pixTick;
    pclkOut  = (stb.running & stb.pclkPhase) ^ invPclk;
    hsyncOut = hsyncRaw ^ invHsync;
    vsyncOut = vsyncRaw ^ invVsync;
    denOut   = denRaw ^ invDen;
    lineEnd  = lineEndRaw;
  end

endmodule

// File: tb/sim_tft_raster_gen.sv
`timescale 1ns/100ps
module sim_tft_raster_gen;
  localparam int DW = 10;
  localparam int HW = 10;
  localparam int VW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] divSel;
  logic [HW-1:0] hS, hB, hA, hF;
  logic [VW-1:0] vS, vB, vA, vF;
  logic invH, invV, invD, invP;
  logic pixEn, pclkOut, hsyncOut, vsyncOut, denOut, lineEnd;
  logic [HW+1:0] hPos;
  logic [VW+1:0] vPos;

  always #2.5 clk = ~clk;

  tft_raster_gen #(.DIV_W(DW), .H_W(HW), .V_W(VW)) u0 (
    .clk(clk), .rst(rst), .divSel(divSel),
    .hSyncLen(hS), .hBackLen(hB), .hActLen(hA), .hFrontLen(hF),
    .vSyncLen(vS), .vBackLen(vB), .vActLen(vA), .vFrontLen(vF),
    .invHsync(invH), .invVsync(invV), .invDen(invD), .invPclk(invP),
    .pixEn(pixEn), .pclkOut(pclkOut), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .denOut(denOut), .lineEnd(lineEnd), .hPos(hPos), .vPos(vPos)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    hs, vs, de, le, pc;
    int    h, v;
    string tag;
  } item_t;
  item_t q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string pick(input string tag, input string dflt);
    return (tag != "") ? tag : dflt;
  endfunction

  task automatic setCfg(input int d, input int hs, input int hb, input int ha, input int hf,
                        input int vs, input int vb, input int va, input int vf);
    divSel = DW'(d);
    hS = HW'(hs); hB = HW'(hb); hA = HW'(ha); hF = HW'(hf);
    vS = VW'(vs); vB = VW'(vb); vA = VW'(va); vF = VW'(vf);
  endtask

  task automatic pushIdle(input string tag);
    item_t e;
    e.hs = 0; e.vs = 0; e.de = 0; e.le = 0; e.pc = 0;
    e.h = 0; e.v = 0; e.tag = tag;
    q.push_back(e);
  endtask

  // Expected pixel-by-pixel contents of one frame, from the requirements.
  task automatic pushFrame(input int hs, input int hb, input int ha, input int hf,
                           input int vs, input int vb, input int va, input int vf,
                           input string tag);
    int ht = hs + hb + ha + hf + 4;
    int vt = vs + vb + va + vf + 4;
    for (int v = 0; v < vt; v++) begin
      for (int h = 0; h < ht; h++) begin
        item_t e;
        e.hs  = (h <= hs);
        e.vs  = (v <= vs);
        e.de  = (h >= hs + hb + 2) && (h <= hs + hb + ha + 2) &&
                (v >= vs + vb + 2) && (v <= vs + vb + va + 2);
        e.le  = (h == ht - 1);
        e.pc  = 1;
        e.h   = h;
        e.v   = v;
        e.tag = tag;
        q.push_back(e);
      end
    end
  endtask

  task automatic checkIdle(input string req);
    chk(pixEn == 1'b0, req, "pixEn in reset", int'(pixEn), 0);
    chk(hsyncOut == invH, req, "idle hsync", int'(hsyncOut), int'(invH));
    chk(vsyncOut == invV, req, "idle vsync", int'(vsyncOut), int'(invV));
    chk(denOut == invD, req, "idle den", int'(denOut), int'(invD));
    chk(pclkOut == invP, req, "idle pclk", int'(pclkOut), int'(invP));
    chk(lineEnd == 1'b0, req, "idle lineEnd", int'(lineEnd), 0);
    chk(hPos == '0 && vPos == '0, req, "idle position", int'(hPos) + int'(vPos), 0);
  endtask

  // Measures the spacing between two pixEn pulses and the pclk high time.
  task automatic measure(input int d, input string reqGap, input string reqHigh);
    int gap = 0;
    int high = 0;
    @(negedge clk);
    while (pixEn !== 1'b1) @(negedge clk);
    do begin
      @(negedge clk);
      gap++;
      if (pclkOut != invP) high++;
    end while (pixEn !== 1'b1);
    chk(gap == 2 * (d + 1), reqGap, "pixEn spacing", gap, 2 * (d + 1));
    chk(high == d + 1, reqHigh, "pclk active cycles", high, d + 1);
  endtask

  // Monitor: pops one expected pixel per pixEn and compares.
  always @(negedge clk) begin
    if (pixEn === 1'b1 && q.size() != 0) begin
      item_t e;
      e = q.pop_front();
      chk(hsyncOut == (e.hs ^ invH), pick(e.tag, "R4"), "hsync",
          int'(hsyncOut), int'(e.hs ^ invH));
      chk(vsyncOut == (e.vs ^ invV), pick(e.tag, "R6"), "vsync",
          int'(vsyncOut), int'(e.vs ^ invV));
      chk(denOut == (e.de ^ invD), pick(e.tag, "R7"), "den",
          int'(denOut), int'(e.de ^ invD));
      chk(lineEnd == e.le, pick(e.tag, "R5"), "lineEnd", int'(lineEnd), int'(e.le));
      chk(pclkOut == (e.pc ^ invP), pick(e.tag, "R3"), "pclk at tick",
          int'(pclkOut), int'(e.pc ^ invP));
      chk(int'(hPos) == e.h, pick(e.tag, "R4"), "hPos", int'(hPos), e.h);
      chk(int'(vPos) == e.v, pick(e.tag, "R6"), "vPos", int'(vPos), e.v);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Phase 1: reset state, fastest divisor, mid-frame field change (R1, R2, R3, R8)
    invH = 0; invV = 0; invD = 0; invP = 0;
    setCfg(0, 0, 1, 3, 0, 0, 0, 1, 0);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    checkIdle("R1");
    pushIdle("R1");
    pushFrame(0, 1, 3, 0, 0, 0, 1, 0, "");
    pushFrame(1, 0, 4, 1, 1, 0, 2, 0, "R8");
    rst = 1'b0;
    measure(0, "R2", "R3");
    repeat (20) @(negedge clk);
    setCfg(2, 1, 0, 4, 1, 1, 0, 2, 0);
    while (q.size() != 0) @(negedge clk);

    // Phase 2: all outputs inverted (R9)
    rst = 1'b1;
    invH = 1; invV = 1; invD = 1; invP = 1;
    setCfg(1, 0, 0, 1, 0, 0, 1, 0, 0);
    repeat (4) @(negedge clk);
    checkIdle("R9");
    pushIdle("R9");
    pushFrame(0, 0, 1, 0, 0, 1, 0, 0, "R9");
    rst = 1'b0;
    while (q.size() != 0) @(negedge clk);

    // Phase 3: maximum divisor (R10)
    rst = 1'b1;
    invH = 0; invV = 0; invD = 0; invP = 0;
    setCfg(1023, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    measure(1023, "R10", "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule